// File: doc/BRIEF.md
# Bubble Flow Control Ring Router

This block is one node of a unidirectional ring that links a stack of dies. Each node has one ring input, one ring output and a local port toward the on-die network. It keeps one shared input buffer for ring arrivals and sends each arriving packet either to the local port (eject) or on toward the next node (forward). It arbitrates the ring output between forwarded traffic and packets injected from the local side, and it tracks downstream buffer space with credits.

Every message class uses the same buffer. Cyclic deadlock on the ring is avoided by a bubble rule instead of duplicated virtual channels. A packet already on the ring may advance when the next buffer can hold that packet. A new packet from the local port may enter only if the next buffer can hold it and still keep room for one more whole packet. That spare room means the ring can never fill up completely.

A flit accepted into the input buffer appears on the ring output or the eject output one cycle after it reaches the head of the buffer. Switch traversal is one register stage and the output register drives the link.

Top module: `ring_bubble_router`

## Requirements
- R1: During reset and straight after it, `ring_out_valid_o`, `ej_valid_o` and `ring_in_credit_o` are low. The downstream credit count starts at BUF_DEPTH (5), so an injected head is accepted at once.
- R2: Flit layout: bit FLIT_W-1 marks a head flit, bit FLIT_W-2 marks a tail flit, the DEST_W (3) bits below them hold the destination die, and the remaining low bits are payload. A packet is PKT_FLITS (2) flits: a head, then a tail.
- R3: A ring packet whose head destination equals NODE_ID is delivered whole on `ej_valid_o`/`ej_flit_o`. Its tail follows the head's route.
- R4: A ring packet for any other die is forwarded on `ring_out_valid_o`/`ring_out_flit_o`, with flit order kept.
- R5: A forwarded ring head leaves only when the downstream credit count is at least PKT_FLITS. With exactly PKT_FLITS credits it goes; with fewer it waits.
- R6: An injected head is accepted (`inj_ready_o` high) only when the downstream credit count is at least 2*PKT_FLITS. It is refused at 2*PKT_FLITS-1 credits and accepted at exactly 2*PKT_FLITS.
- R7: When a forwarded ring head and an injected head both request a free output, the ring head goes first.
- R8: Once a head has left on the ring output, no other packet's flit uses that output until the matching tail has left.
- R9: The downstream credit count drops by one for each flit sent and rises by one for each cycle `ring_out_credit_i` is high. No flit is sent when it is zero.
- R10: For every flit that leaves the input buffer, `ring_in_credit_o` pulses for one cycle. The pulse comes in the cycle the flit appears on the eject or ring output.
- R11: One shared input buffer of BUF_DEPTH flits holds ring arrivals of all message classes. It is never written when full and never read when empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ring_in_valid_i | input | 1 | Flit arriving from the upstream node |
| ring_in_flit_i | input | FLIT_W | Arriving flit |
| ring_in_credit_o | output | 1 | One credit returned upstream |
| ring_out_valid_o | output | 1 | Flit sent to the downstream node |
| ring_out_flit_o | output | FLIT_W | Sent flit |
| ring_out_credit_i | input | 1 | One credit returned by downstream |
| inj_valid_i | input | 1 | Local flit offered for injection |
| inj_flit_i | input | FLIT_W | Offered local flit |
| inj_ready_o | output | 1 | Offered flit taken this cycle |
| ej_valid_o | output | 1 | Flit delivered to the local port |
| ej_flit_o | output | FLIT_W | Delivered flit |

## Verification
The bench runs several traffic patterns:
- A mixed ring stream of packets for the local die and for other dies. This separates the eject and forward routes, and it checks that a tail follows its head.
- Local injection with credits freely returned. This shows the normal injection path.
- Credits withheld by the bench acting as downstream. This walks the count through 3, 4, 2, 0 and 1, so the injection threshold and the transit threshold are each tested on both sides of their boundary.
- A ring packet whose tail is held back while an injected packet waits. The tail is then released together with a second ring packet. This shows whether the output lock holds and whether the ring wins the tie.

// File: rtl/rbr_pkg.sv
package rbr_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_RING = 2'd1,
    OWN_INJ  = 2'd2
  } owner_e;
endpackage

// File: rtl/rbr_in_buf.sv
module rbr_in_buf #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  assign data_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));

  assert_no_overflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i));
  assert_no_underflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/rbr_credit_ctr.sv
module rbr_credit_ctr #(
  parameter int DEPTH = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       take_i,
  input  logic                       give_i,
  output logic [$clog2(DEPTH+1)-1:0] credits_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cred_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cred_q <= CW'(DEPTH);
    else         cred_q <= cred_q + CW'(give_i) - CW'(take_i);
  end

  assign credits_o = cred_q;

  assert_credit_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cred_q) <= DEPTH);
  assert_no_send_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> (cred_q != '0));
endmodule

// File: rtl/rbr_out_arb.sv
module rbr_out_arb
  import rbr_pkg::*;
#(
  parameter int PKT_FLITS = 2,
  parameter int CW        = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] credits_i,
  input  logic          ring_valid_i,
  input  logic          ring_head_i,
  input  logic          ring_tail_i,
  input  logic          inj_valid_i,
  input  logic          inj_head_i,
  input  logic          inj_tail_i,
  output logic          ring_gnt_o,
  output logic          inj_gnt_o
);
  owner_e own_q, own_d;
  logic   room_ring, room_inj, room_body, ring_head_wait;

  // bubble rule: transit needs one packet of room, injection needs two
  assign room_ring      = int'(credits_i) >= PKT_FLITS;
  assign room_inj       = int'(credits_i) >= 2 * PKT_FLITS;
  assign room_body      = credits_i != '0;
  assign ring_head_wait = ring_valid_i && ring_head_i;

  assign ring_gnt_o = ring_valid_i &&
    (ring_head_i ? (own_q == OWN_NONE && room_ring) : (own_q == OWN_RING && room_body));
  assign inj_gnt_o  = inj_valid_i &&
    (inj_head_i ? (own_q == OWN_NONE && !ring_head_wait && room_inj)
                : (own_q == OWN_INJ && room_body));

  always_comb begin
    own_d = own_q;
    if (ring_gnt_o)     own_d = ring_tail_i ? OWN_NONE : OWN_RING;
    else if (inj_gnt_o) own_d = inj_tail_i  ? OWN_NONE : OWN_INJ;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) own_q <= OWN_NONE;
    else         own_q <= own_d;
  end

  assert_ring_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ring_head_wait && own_q == OWN_NONE && room_ring) |-> !inj_gnt_o);
  assert_lock_ring_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_q == OWN_RING) |-> !inj_gnt_o);
  assert_lock_inj_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_q == OWN_INJ) |-> !ring_gnt_o);
endmodule

// File: rtl/ring_bubble_router.sv
module ring_bubble_router #(
  parameter int FLIT_W    = 16,
  parameter int DEST_W    = 3,
  parameter int BUF_DEPTH = 5,
  parameter int PKT_FLITS = 2,
  parameter int NODE_ID   = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ring_in_valid_i,
  input  logic [FLIT_W-1:0] ring_in_flit_i,
  output logic              ring_in_credit_o,
  output logic              ring_out_valid_o,
  output logic [FLIT_W-1:0] ring_out_flit_o,
  input  logic              ring_out_credit_i,
  input  logic              inj_valid_i,
  input  logic [FLIT_W-1:0] inj_flit_i,
  output logic              inj_ready_o,
  output logic              ej_valid_o,
  output logic [FLIT_W-1:0] ej_flit_o
);
  localparam int HEAD_BIT = FLIT_W - 1;
  localparam int TAIL_BIT = FLIT_W - 2;
  localparam int DEST_LSB = FLIT_W - 2 - DEST_W;
  localparam int CW       = $clog2(BUF_DEPTH + 1);

  logic [FLIT_W-1:0] buf_flit;
  logic              buf_empty, buf_full, buf_valid;
  logic              to_eject, to_fwd, pop, route_ej_q;
  logic              ring_gnt, inj_gnt;
  logic [CW-1:0]     credits;
  logic              out_valid_q, ej_valid_q, cred_ret_q;
  logic [FLIT_W-1:0] out_flit_q, ej_flit_q;

  rbr_in_buf #(.WIDTH(FLIT_W), .DEPTH(BUF_DEPTH)) i_in_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (ring_in_valid_i),
    .data_i  (ring_in_flit_i),
    .pop_i   (pop),
    .data_o  (buf_flit),
    .empty_o (buf_empty),
    .full_o  (buf_full)
  );

  assign buf_valid = !buf_empty;
  // route computed on head, body flits follow the held route
  assign to_eject = buf_valid && (buf_flit[HEAD_BIT]
                    ? (buf_flit[DEST_LSB +: DEST_W] == DEST_W'(NODE_ID)) : route_ej_q);
  assign to_fwd   = buf_valid && !to_eject;
  assign pop      = to_eject || ring_gnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       route_ej_q <= 1'b0;
    else if (pop && buf_flit[HEAD_BIT]) route_ej_q <= to_eject;
  end

  rbr_credit_ctr #(.DEPTH(BUF_DEPTH)) i_credit (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (ring_gnt || inj_gnt),
    .give_i    (ring_out_credit_i),
    .credits_o (credits)
  );

  rbr_out_arb #(.PKT_FLITS(PKT_FLITS), .CW(CW)) i_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .credits_i    (credits),
    .ring_valid_i (to_fwd),
    .ring_head_i  (buf_flit[HEAD_BIT]),
    .ring_tail_i  (buf_flit[TAIL_BIT]),
    .inj_valid_i  (inj_valid_i),
    .inj_head_i   (inj_flit_i[HEAD_BIT]),
    .inj_tail_i   (inj_flit_i[TAIL_BIT]),
    .ring_gnt_o   (ring_gnt),
    .inj_gnt_o    (inj_gnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_flit_q  <= '0;
      ej_valid_q  <= 1'b0;
      ej_flit_q   <= '0;
      cred_ret_q  <= 1'b0;
    end else begin
      out_valid_q <= ring_gnt || inj_gnt;
      if (ring_gnt)     out_flit_q <= buf_flit;
      else if (inj_gnt) out_flit_q <= inj_flit_i;
      ej_valid_q <= to_eject;
      if (to_eject) ej_flit_q <= buf_flit;
      cred_ret_q <= pop;
    end
  end

  assign ring_out_valid_o = out_valid_q;
  assign ring_out_flit_o  = out_flit_q;
  assign ej_valid_o       = ej_valid_q;
  assign ej_flit_o        = ej_flit_q;
  assign ring_in_credit_o = cred_ret_q;
  assign inj_ready_o      = inj_gnt;

  // checking state: a packet is open on the ring output
  logic out_open_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               out_open_q <= 1'b0;
    else if (ring_out_valid_o) out_open_q <= !ring_out_flit_o[TAIL_BIT];
  end

  assert_no_interleave_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ring_out_valid_o && ring_out_flit_o[HEAD_BIT]) |-> !out_open_q);
  assert_bubble_inject_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inj_ready_o && inj_flit_i[HEAD_BIT]) |-> (int'(credits) >= 2 * PKT_FLITS));
  assert_eject_credit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ej_valid_o |-> ring_in_credit_o);
  assert_full_no_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_full && !pop) |-> !ring_in_valid_i);
endmodule

// File: tb/test_ring_bubble_router.sv
module test_ring_bubble_router;
  localparam int FW    = 16;
  localparam int DEPTH = 5;
  localparam int NODE  = 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ring_in_valid_i = 1'b0;
  logic [FW-1:0] ring_in_flit_i = '0;
  logic          ring_in_credit_o;
  logic          ring_out_valid_o;
  logic [FW-1:0] ring_out_flit_o;
  logic          ring_out_credit_i = 1'b0;
  logic          inj_valid_i = 1'b0;
  logic [FW-1:0] inj_flit_i = '0;
  logic          inj_ready_o;
  logic          ej_valid_o;
  logic [FW-1:0] ej_flit_o;

  always #5 clk = ~clk;

  ring_bubble_router #(.FLIT_W(FW), .DEST_W(3), .BUF_DEPTH(DEPTH),
                       .PKT_FLITS(2), .NODE_ID(NODE)) i_ring_bubble_router (
    .clk_i(clk), .rst_ni(rst_ni),
    .ring_in_valid_i(ring_in_valid_i), .ring_in_flit_i(ring_in_flit_i),
    .ring_in_credit_o(ring_in_credit_o),
    .ring_out_valid_o(ring_out_valid_o), .ring_out_flit_o(ring_out_flit_o),
    .ring_out_credit_i(ring_out_credit_i),
    .inj_valid_i(inj_valid_i), .inj_flit_i(inj_flit_i), .inj_ready_o(inj_ready_o),
    .ej_valid_o(ej_valid_o), .ej_flit_o(ej_flit_o)
  );

  logic [FW-1:0] exp_fwd[$];
  logic [FW-1:0] exp_ej[$];
  int total = 0, bad = 0;
  int up_cred = DEPTH;
  int ds_free = DEPTH, ds_held = 0, rel_allow = 0;
  bit ds_hold = 1'b0;
  int fwd_seen = 0, ej_seen = 0;

  function automatic logic [FW-1:0] mk(bit hd, bit tl, logic [2:0] dst, logic [10:0] pay);
    return {hd, tl, dst, pay};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_ring(logic [FW-1:0] f);
    while (up_cred == 0) @(negedge clk);
    ring_in_valid_i = 1'b1;
    ring_in_flit_i  = f;
    up_cred--;
    @(negedge clk);
    ring_in_valid_i = 1'b0;
  endtask

  task automatic send_inj(logic [FW-1:0] f);
    inj_valid_i = 1'b1;
    inj_flit_i  = f;
    #1;
    while (!inj_ready_o) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    inj_valid_i = 1'b0;
  endtask

  task automatic probe_inj(logic [FW-1:0] f, bit exp, string what);
    inj_valid_i = 1'b1;
    inj_flit_i  = f;
    #1;
    check(inj_ready_o == exp, "R6", what, int'(inj_ready_o), int'(exp));
    #1;
    inj_valid_i = 1'b0;
  endtask

  task automatic push_pkt_fwd(logic [2:0] dst, logic [10:0] pay);
    exp_fwd.push_back(mk(1, 0, dst, pay));
    exp_fwd.push_back(mk(0, 1, dst, pay + 11'd1));
  endtask

  // monitor / scoreboard and downstream credit model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni) begin
        if (ring_in_credit_o) up_cred++;
        if (ring_out_valid_o) begin
          fwd_seen++;
          check(ds_free != 0, "R9", "flit sent with no downstream credit", ds_free, 1);
          ds_free--;
          ds_held++;
          if (exp_fwd.size() == 0)
            check(1'b0, "R4/R7/R8", "unexpected ring flit", int'(ring_out_flit_o), 0);
          else begin
            logic [FW-1:0] e;
            e = exp_fwd.pop_front();
            check(ring_out_flit_o == e, "R4/R7/R8", "ring out flit", int'(ring_out_flit_o), int'(e));
          end
        end
        if (ej_valid_o) begin
          ej_seen++;
          check(ring_in_credit_o, "R10", "credit with ejected flit", int'(ring_in_credit_o), 1);
          if (exp_ej.size() == 0)
            check(1'b0, "R3", "unexpected eject flit", int'(ej_flit_o), 0);
          else begin
            logic [FW-1:0] e;
            e = exp_ej.pop_front();
            check(ej_flit_o == e, "R3", "eject flit", int'(ej_flit_o), int'(e));
          end
        end
        ring_out_credit_i = 1'b0;
        if (ds_held > 0 && (!ds_hold || rel_allow > 0)) begin
          ring_out_credit_i = 1'b1;
          ds_held--;
          ds_free++;
          if (ds_hold) rel_allow--;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R1 watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    check(!ring_out_valid_o, "R1", "ring out in reset", int'(ring_out_valid_o), 0);
    check(!ej_valid_o, "R1", "eject in reset", int'(ej_valid_o), 0);
    check(!ring_in_credit_o, "R1", "credit in reset", int'(ring_in_credit_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    probe_inj(mk(1, 0, 3'd4, 11'h7f0), 1'b1, "R1 full credits after reset");
    @(negedge clk);

    // R2 R3 R4 R11: mixed ring stream, classes in payload, all share buffer
    exp_ej.push_back(mk(1, 0, 3'(NODE), 11'h101));
    exp_ej.push_back(mk(0, 1, 3'(NODE), 11'h102));
    push_pkt_fwd(3'd5, 11'h201);
    exp_ej.push_back(mk(1, 0, 3'(NODE), 11'h401));
    exp_ej.push_back(mk(0, 1, 3'(NODE), 11'h402));
    send_ring(mk(1, 0, 3'(NODE), 11'h101));
    send_ring(mk(0, 1, 3'(NODE), 11'h102));
    send_ring(mk(1, 0, 3'd5, 11'h201));
    send_ring(mk(0, 1, 3'd5, 11'h202));
    send_ring(mk(1, 0, 3'(NODE), 11'h401));
    send_ring(mk(0, 1, 3'(NODE), 11'h402));
    repeat (10) @(negedge clk);
    check(ej_seen == 4, "R3", "ejected flit count", ej_seen, 4);
    check(fwd_seen == 2, "R4", "forwarded flit count", fwd_seen, 2);

    // R6: plain injection
    push_pkt_fwd(3'd1, 11'h301);
    send_inj(mk(1, 0, 3'd1, 11'h301));
    send_inj(mk(0, 1, 3'd1, 11'h302));
    repeat (8) @(negedge clk);
    check(fwd_seen == 4, "R6", "injected flits forwarded", fwd_seen, 4);

    // R5 R6 R9: bubble thresholds with credits withheld
    ds_hold = 1'b1;
    base = fwd_seen;
    push_pkt_fwd(3'd6, 11'h501);
    send_inj(mk(1, 0, 3'd6, 11'h501));
    send_inj(mk(0, 1, 3'd6, 11'h502));
    repeat (4) @(negedge clk);
    probe_inj(mk(1, 0, 3'd6, 11'h601), 1'b0, "refused at 3 credits");
    @(negedge clk);
    rel_allow = 1;
    repeat (4) @(negedge clk);
    probe_inj(mk(1, 0, 3'd6, 11'h601), 1'b1, "accepted at 4 credits");
    @(negedge clk);
    push_pkt_fwd(3'd7, 11'h601);
    send_inj(mk(1, 0, 3'd7, 11'h601));
    send_inj(mk(0, 1, 3'd7, 11'h602));
    repeat (4) @(negedge clk);
    push_pkt_fwd(3'd0, 11'h701);
    send_ring(mk(1, 0, 3'd0, 11'h701));
    send_ring(mk(0, 1, 3'd0, 11'h702));
    repeat (6) @(negedge clk);
    check(fwd_seen == base + 6, "R5", "ring head sent at exactly 2 credits", fwd_seen - base, 6);
    send_ring(mk(1, 0, 3'd3, 11'h711));
    send_ring(mk(0, 1, 3'd3, 11'h712));
    repeat (8) @(negedge clk);
    check(fwd_seen == base + 6, "R5", "ring head held at 0 credits", fwd_seen - base, 6);
    rel_allow = 1;
    repeat (6) @(negedge clk);
    check(fwd_seen == base + 6, "R5", "ring head held at 1 credit", fwd_seen - base, 6);
    push_pkt_fwd(3'd3, 11'h711);
    ds_hold = 1'b0;
    repeat (12) @(negedge clk);
    check(fwd_seen == base + 8, "R9", "stalled packet sent after credits return", fwd_seen - base, 8);

    // R7 R8: ring tail held while injection waits, then ring tie-break
    base = fwd_seen;
    push_pkt_fwd(3'd4, 11'h041);
    push_pkt_fwd(3'd5, 11'h051);
    push_pkt_fwd(3'd6, 11'h061);
    send_ring(mk(1, 0, 3'd4, 11'h041));
    repeat (4) @(negedge clk);
    fork
      begin
        send_inj(mk(1, 0, 3'd6, 11'h061));
        send_inj(mk(0, 1, 3'd6, 11'h062));
      end
      begin
        repeat (3) @(negedge clk);
        check(fwd_seen == base + 1, "R8", "output locked until ring tail", fwd_seen - base, 1);
        send_ring(mk(0, 1, 3'd4, 11'h042));
        send_ring(mk(1, 0, 3'd5, 11'h051));
        send_ring(mk(0, 1, 3'd5, 11'h052));
      end
    join
    repeat (12) @(negedge clk);
    check(fwd_seen == base + 6, "R7", "all flits after tie", fwd_seen - base, 6);

    check(exp_fwd.size() == 0, "R4", "forward queue drained", exp_fwd.size(), 0);
    check(exp_ej.size() == 0, "R3", "eject queue drained", exp_ej.size(), 0);
    check(up_cred == DEPTH, "R10", "upstream credits all returned", up_cred, DEPTH);
    check(ds_free == DEPTH, "R9", "downstream credits all returned", ds_free, DEPTH);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule